// File: doc/BRIEF.md
# DDR2 Self-Refresh Exit Sequencer

This block takes a DDR2 memory controller from reset, or from self-refresh, into normal operation without software stepping through each stage. A one-cycle start pulse runs a fixed ordering. First the pad DLL reset is pulled low and the pad frequency code is applied. The DLL reset is then released, and the block waits a programmable settling time. Next it latches the pad drive-strength, on-die-termination and off-chip-driver settings. After that it raises CKE and waits a programmable self-refresh-exit time. It then issues a single auto-refresh command and opens host access. Periodic automatic refresh is switched on a fixed number of cycles later, which leaves time for the refresh-interval settings to be in place.

All waits are counted in memory clock cycles, because the controller and memory clocks run at a 1:1 ratio. A wait input of 0 behaves as 1. There is no data stream at this boundary, so there is no valid/ready handshake. `start_i` is a plain pulse that is honoured only while the block is idle, and every other pin is a level-type control or status signal. The pad settings given to the block must match the values written to the memory's extended mode register 1.

Top module: `ddr2_wake_seq`

## Requirements
- R1: While reset is asserted and after it is released, cke_o, dll_rst_n_o, acc_en_o, arf_en_o, busy_o and done_o are 0, and the command pins carry NOP (cs_n_o=1, ras_n_o=1, cas_n_o=1, we_n_o=1).
- R2: When start_i is high at a clock edge while busy_o is 0, then from that edge (edge 0) busy_o is 1 and cke_o, dll_rst_n_o, acc_en_o, arf_en_o and done_o are 0.
- R3: dll_freq_o takes the value of freq_code_i at edge 1, while dll_rst_n_o is still 0. dll_rst_n_o goes to 1 at edge 2.
- R4: Let W be max(dll_wait_i, 1). The pad outputs take their new values W cycles after the DLL reset is released.
- R5: pad_drv_o, pad_odt_o and pad_ocd_o equal the values of pad_drv_i, pad_odt_i and pad_ocd_i captured when they were applied, and they hold those values until the next run applies new ones.
- R6: cke_o goes to 1 one cycle after the pad settings are applied. cke_o is never 1 while dll_rst_n_o is 0.
- R7: Let X be max(xsnr_wait_i, 1). Exactly one REF command (cs_n_o=0, ras_n_o=0, cas_n_o=0, we_n_o=1) is driven for one cycle, X cycles after cke_o rises. At all other times the command pins carry NOP, and a command is driven only while cke_o is 1.
- R8: acc_en_o goes to 1 in the cycle after the REF command.
- R9: arf_en_o and done_o go to 1 ACC_GAP cycles (default 8) after acc_en_o, and busy_o falls at the same edge. arf_en_o is never 1 while acc_en_o is 0.
- R10: A start_i pulse while busy_o is 1 has no effect. The running sequence keeps its timing and issues one REF command only.
- R11: done_o stays at 1 while the block is idle until the next accepted start, and done_o is never 1 while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock (1:1 with memory clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured only while idle |
| dll_wait_i | input | CNT_W | DLL settling time in cycles |
| xsnr_wait_i | input | CNT_W | Self-refresh-exit to non-read wait in cycles |
| freq_code_i | input | FREQ_W | Pad frequency code |
| pad_drv_i | input | DRV_W | Pad drive-strength setting |
| pad_odt_i | input | ODT_W | Pad on-die-termination setting |
| pad_ocd_i | input | OCD_W | Pad off-chip-driver setting |
| dll_rst_n_o | output | 1 | Pad DLL reset, 0 = held in reset |
| dll_freq_o | output | FREQ_W | Applied frequency code |
| pad_drv_o | output | DRV_W | Applied drive strength |
| pad_odt_o | output | ODT_W | Applied termination |
| pad_ocd_o | output | OCD_W | Applied off-chip-driver setting |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| acc_en_o | output | 1 | Host access enabled |
| arf_en_o | output | 1 | Periodic auto-refresh enabled |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |

## Verification
The assertions check, on every cycle, these ordering invariants: CKE only with the DLL released, commands only with CKE high, a REF that never lasts past one cycle, refresh enable only with access enable, access opening only right after a REF, done never together with busy, and a wait counter that never wraps. Only the bench scenarios can show the cycle distances between stages, for each programmed wait and with zero waits treated as one. The same applies to the captured frequency and pad values, a start pulse ignored while a run is in progress, and done persisting until the next start.

// File: rtl/ddr2_wake_pkg.sv
package ddr2_wake_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DLL_LOW,
    ST_SET_FREQ,
    ST_DLL_WAIT,
    ST_PAD_SET,
    ST_XSNR_WAIT,
    ST_REF_CMD,
    ST_GAP_WAIT
  } wake_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } mem_cmd_t;

  localparam mem_cmd_t CMD_NOP = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam mem_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // a count of 0 or 1 means the wait is over, so a zero load acts as one cycle
  assign expire_o = (cnt_q <= CNT_W'(1));

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

endmodule

// File: rtl/wake_cap_reg.sv
module wake_cap_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= d_i;
    end
  end

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o));

endmodule

// File: rtl/wake_cmd_drv.sv
module wake_cmd_drv
  import ddr2_wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue_ref_i,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);

  mem_cmd_t cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= CMD_NOP;
    end else begin
      cmd_q <= issue_ref_i ? CMD_REF : CMD_NOP;
    end
  end

  assign cs_n_o  = cmd_q.cs_n;
  assign ras_n_o = cmd_q.ras_n;
  assign cas_n_o = cmd_q.cas_n;
  assign we_n_o  = cmd_q.we_n;

  // R7
  ref_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |=> cs_n_o);

endmodule

// File: rtl/ddr2_wake_seq.sv
module ddr2_wake_seq
  import ddr2_wake_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int FREQ_W  = 4,
  parameter int DRV_W   = 2,
  parameter int ODT_W   = 2,
  parameter int OCD_W   = 3,
  parameter int ACC_GAP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  dll_wait_i,
  input  logic [CNT_W-1:0]  xsnr_wait_i,
  input  logic [FREQ_W-1:0] freq_code_i,
  input  logic [DRV_W-1:0]  pad_drv_i,
  input  logic [ODT_W-1:0]  pad_odt_i,
  input  logic [OCD_W-1:0]  pad_ocd_i,
  output logic              dll_rst_n_o,
  output logic [FREQ_W-1:0] dll_freq_o,
  output logic [DRV_W-1:0]  pad_drv_o,
  output logic [ODT_W-1:0]  pad_odt_o,
  output logic [OCD_W-1:0]  pad_ocd_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              acc_en_o,
  output logic              arf_en_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(ACC_GAP);

  wake_state_e      state_q, state_d;
  logic             t_load, t_expire;
  logic [CNT_W-1:0] t_val;
  logic             accept, freq_load, pad_load, issue_ref;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign freq_load = (state_q == ST_DLL_LOW);
  assign pad_load  = (state_q == ST_DLL_WAIT) && t_expire;
  assign issue_ref = (state_q == ST_XSNR_WAIT) && t_expire;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_DLL_LOW;
      ST_DLL_LOW:   state_d = ST_SET_FREQ;
      ST_SET_FREQ:  state_d = ST_DLL_WAIT;
      ST_DLL_WAIT:  if (t_expire) state_d = ST_PAD_SET;
      ST_PAD_SET:   state_d = ST_XSNR_WAIT;
      ST_XSNR_WAIT: if (t_expire) state_d = ST_REF_CMD;
      ST_REF_CMD:   state_d = ST_GAP_WAIT;
      ST_GAP_WAIT:  if (t_expire) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (state_q)
      ST_SET_FREQ: begin t_load = 1'b1; t_val = dll_wait_i;  end
      ST_PAD_SET:  begin t_load = 1'b1; t_val = xsnr_wait_i; end
      ST_REF_CMD:  begin t_load = 1'b1; t_val = GAP_LD;      end
      default:     begin t_load = 1'b0; t_val = '0;          end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      dll_rst_n_o <= 1'b0;
      cke_o       <= 1'b0;
      acc_en_o    <= 1'b0;
      arf_en_o    <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        dll_rst_n_o <= 1'b0;
        cke_o       <= 1'b0;
        acc_en_o    <= 1'b0;
        arf_en_o    <= 1'b0;
        done_o      <= 1'b0;
      end
      if (state_q == ST_SET_FREQ) dll_rst_n_o <= 1'b1;
      if (state_q == ST_PAD_SET)  cke_o       <= 1'b1;
      if (state_q == ST_REF_CMD)  acc_en_o    <= 1'b1;
      if (state_q == ST_GAP_WAIT && t_expire) begin
        arf_en_o <= 1'b1;
        done_o   <= 1'b1;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  wake_timer #(.CNT_W(CNT_W)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (t_load),
    .load_val_i(t_val),
    .expire_o  (t_expire)
  );

  wake_cap_reg #(.W(FREQ_W)) i_freq (
    .clk(clk), .rst_n(rst_n), .load_i(freq_load), .d_i(freq_code_i), .q_o(dll_freq_o));
  wake_cap_reg #(.W(DRV_W)) i_drv (
    .clk(clk), .rst_n(rst_n), .load_i(pad_load), .d_i(pad_drv_i), .q_o(pad_drv_o));
  wake_cap_reg #(.W(ODT_W)) i_odt (
    .clk(clk), .rst_n(rst_n), .load_i(pad_load), .d_i(pad_odt_i), .q_o(pad_odt_o));
  wake_cap_reg #(.W(OCD_W)) i_ocd (
    .clk(clk), .rst_n(rst_n), .load_i(pad_load), .d_i(pad_ocd_i), .q_o(pad_ocd_o));

  wake_cmd_drv i_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_ref_i(issue_ref),
    .cs_n_o     (cs_n_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .we_n_o     (we_n_o)
  );

  // R6
  cke_after_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke_o |-> dll_rst_n_o);

  // R7
  cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> cke_o);

  // R8
  acc_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_en_o) |-> $past(!cs_n_o));

  // R9
  arf_needs_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arf_en_o |-> acc_en_o);

  // R11
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: tb/test_ddr2_wake_seq.sv
`timescale 1ns/1ps
module test_ddr2_wake_seq;

  localparam int GAP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] dll_wait_i = '0, xsnr_wait_i = '0;
  logic [3:0]  freq_code_i = '0;
  logic [1:0]  pad_drv_i = '0, pad_odt_i = '0;
  logic [2:0]  pad_ocd_i = '0;
  logic        dll_rst_n_o, cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic        acc_en_o, arf_en_o, busy_o, done_o;
  logic [3:0]  dll_freq_o;
  logic [1:0]  pad_drv_o, pad_odt_o;
  logic [2:0]  pad_ocd_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ddr2_wake_seq i_ddr2_wake_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dll_wait_i(dll_wait_i), .xsnr_wait_i(xsnr_wait_i), .freq_code_i(freq_code_i),
    .pad_drv_i(pad_drv_i), .pad_odt_i(pad_odt_i), .pad_ocd_i(pad_ocd_i),
    .dll_rst_n_o(dll_rst_n_o), .dll_freq_o(dll_freq_o),
    .pad_drv_o(pad_drv_o), .pad_odt_o(pad_odt_o), .pad_ocd_o(pad_ocd_o),
    .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .acc_en_o(acc_en_o), .arf_en_o(arf_en_o), .busy_o(busy_o), .done_o(done_o));

  // {dll_wait[42:27], xsnr_wait[26:11], freq[10:7], drv[6:5], odt[4:3], ocd[2:0]}
  localparam logic [42:0] VEC [5] = '{
    {16'd5,   16'd3,  4'd3,  2'd1, 2'd2, 3'd5},
    {16'd1,   16'd1,  4'd7,  2'd2, 2'd1, 3'd2},
    {16'd0,   16'd0,  4'd9,  2'd3, 2'd3, 3'd7},
    {16'd40,  16'd12, 4'd2,  2'd0, 2'd1, 3'd1},
    {16'd300, 16'd25, 4'd15, 2'd1, 2'd0, 3'd6}
  };

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input logic [42:0] v, input bit inject);
    int wm, xm, t_freq, t_rel, t_pad, t_cke, t_ref, t_acc, t_arf, nref, ncmd, k;
    bit early_rel, freq_while_low;
    wm = (v[42:27] == 0) ? 1 : int'(v[42:27]);
    xm = (v[26:11] == 0) ? 1 : int'(v[26:11]);
    t_freq = -1; t_rel = -1; t_pad = -1; t_cke = -1; t_ref = -1; t_acc = -1; t_arf = -1;
    nref = 0; ncmd = 0; early_rel = 0; freq_while_low = 0;
    @(negedge clk);
    dll_wait_i = v[42:27]; xsnr_wait_i = v[26:11]; freq_code_i = v[10:7];
    pad_drv_i = v[6:5]; pad_odt_i = v[4:3]; pad_ocd_i = v[2:0];
    start_i = 1'b1;
    k = 0;
    forever begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0) begin
        start_i = 1'b0;
        check("R2 busy at edge 0", busy_o, 1);
        check("R2 cke cleared", cke_o, 0);
        check("R2 done cleared", done_o, 0);
        check("R2 acc/arf cleared", {acc_en_o, arf_en_o}, 0);
      end
      if (inject && k == 6) start_i = 1'b1;
      if (inject && k == 7) start_i = 1'b0;
      if (k <= 1 && dll_rst_n_o) early_rel = 1;
      if (dll_freq_o == v[10:7] && t_freq < 0) begin
        t_freq = k; freq_while_low = !dll_rst_n_o;
      end
      if (dll_rst_n_o && t_rel < 0) t_rel = k;
      if ({pad_drv_o, pad_odt_o, pad_ocd_o} == v[6:0] && t_pad < 0) t_pad = k;
      if (cke_o && t_cke < 0) t_cke = k;
      if (!cs_n_o) ncmd++;
      if (!cs_n_o && !ras_n_o && !cas_n_o && we_n_o) begin
        nref++; if (t_ref < 0) t_ref = k;
      end
      if (acc_en_o && t_acc < 0) t_acc = k;
      if (arf_en_o && t_arf < 0) t_arf = k;
      if (done_o || k > 2000) break;
      k++;
    end
    check("R3 DLL reset low in edges 0-1", early_rel, 0);
    check("R3 freq applied at edge 1", t_freq, 1);
    check("R3 freq applied with DLL in reset", freq_while_low, 1);
    check("R3 DLL released at edge 2", t_rel, 2);
    check("R4 pad apply after DLL wait", t_pad - t_rel, wm);
    check("R5 pad values captured", {pad_drv_o, pad_odt_o, pad_ocd_o}, v[6:0]);
    check("R6 cke one cycle after pads", t_cke - t_pad, 1);
    check("R7 REF after xsnr wait", t_ref - t_cke, xm);
    check("R7 exactly one REF", nref, 1);
    check("R7 no other command", ncmd, 1);
    check("R8 access enable after REF", t_acc - t_ref, 1);
    check("R9 refresh enable gap", t_arf - t_acc, GAP);
    check("R9 done with refresh enable", k, t_arf);
    check("R9 busy falls at completion", busy_o, 0);
    if (inject) check("R10 start while busy ignored (timing)", k, 4 + wm + xm + GAP);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check("R1 cke in reset", cke_o, 0);
    check("R1 DLL reset in reset", dll_rst_n_o, 0);
    check("R1 cmd NOP in reset", {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'b1111);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 flags after reset", {acc_en_o, arf_en_o, busy_o, done_o}, 0);
    check("R1 cke after reset", cke_o, 0);

    for (int i = 0; i < 5; i++) run_seq(VEC[i], i == 3);

    // R11 and R5: done and pad values persist while idle
    pad_drv_i = 2'd3; pad_odt_i = 2'd3; pad_ocd_i = 3'd0; freq_code_i = 4'd0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R11 done held while idle", done_o, 1);
    check("R11 acc/arf held while idle", {acc_en_o, arf_en_o}, 2'b11);
    check("R5 pads held while idle", {pad_drv_o, pad_odt_o, pad_ocd_o}, VEC[4][6:0]);
    check("R3 freq held while idle", dll_freq_o, VEC[4][10:7]);

    // R2/R11: new start clears done
    run_seq(VEC[0], 1'b0);

    // R1: reset mid-run
    @(negedge clk);
    start_i = 1'b1; dll_wait_i = 16'd50;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run busy/dll", {busy_o, dll_rst_n_o, cke_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule